// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver with Line Status

This block turns a 16x oversampled asynchronous serial line into characters. A six-bit framing word sets the character format at run time. The word length can be 5, 6, 7 or 8 bits. Parity can be off, odd, even, or stuck at a fixed level. One or two stop bits are expected. The receiver finds a start edge and checks the start bit at mid-bit. It then samples each later bit at its centre and builds the character least significant bit first.

Each finished character goes into a one-entry holding buffer, and the data-ready flag is raised. Four sticky error flags track the line: overrun, bad parity, bad stop bit, and break. A break is a line held at zero for longer than one whole frame. The host uses two strobes. The data-read strobe takes the character and drops data-ready. The status-read strobe clears the four error flags. Baud division, any FIFO and any loopback path are outside the block. The line input must already be synchronous to `clk`.

Top module: `uart_rx_line`

## Requirements
- R1: Data bits arrive least significant bit first. A character of N bits appears in `rx_char[N-1:0]` and the unused upper bits read zero.
- R2: `frame_cfg[1:0]` selects the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R3: `frame_cfg[3]`=1 adds a parity bit after the data. `frame_cfg[4]`=1 expects an even count of ones over data and parity; 0 expects an odd count. A mismatch sets `parity_err`.
- R4: When `frame_cfg[5]` and `frame_cfg[3]` are both 1, the parity bit must equal the inverse of `frame_cfg[4]`, whatever the data. Any other level sets `parity_err`.
- R5: `frame_cfg[2]`=1 selects two stop bits, and `frame_cfg[2]`=0 selects one. Only the first stop bit is sampled. A zero there sets `framing_err`.
- R6: `break_det` sets when the line stays zero for more than (1 + N + parity + stop bits) x 16 ticks. A low run that ends inside one frame does not set it.
- R7: When a character completes, it is loaded into `rx_char` and `data_ready` goes to 1.
- R8: If a character completes while `data_ready` is 1 and no data read occurs in that cycle, `overrun` sets. The newer character replaces the older one.
- R9: A falling edge starts a frame only if the line is still zero at tick 8 of the start bit. Otherwise the receiver returns to idle and nothing is loaded.
- R10: `rd_data` clears `data_ready`. `rd_status` clears `overrun`, `parity_err`, `framing_err` and `break_det`. A new setting event in the same cycle wins over the clear.
- R11: After reset, all five flags read 0 and `rx_char` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the baud rate |
| rx_in | input | 1 | Serial line, idle high, synchronous to clk |
| frame_cfg | input | 6 | Framing word: [1:0] length, [2] two stops, [3] parity on, [4] even, [5] stick |
| rd_data | input | 1 | Host takes the character |
| rd_status | input | 1 | Host reads line status |
| rx_char | output | 8 | Held received character |
| data_ready | output | 1 | A character is waiting |
| overrun | output | 1 | A character was lost |
| parity_err | output | 1 | Parity mismatch seen |
| framing_err | output | 1 | First stop bit sampled zero |
| break_det | output | 1 | Line held low past a frame time |

## Verification
Clean frames are swept over every word length, all five parity modes, and both stop-bit counts. Each combination carries the data patterns all-zeros, all-ones, 0xA5 and 0x5A. Alternating patterns expose bit-order and truncation faults. All-zeros gives the longest legal low run, which must not be taken for a break. Directed frames then send an inverted parity bit in each parity mode, which separates odd, even and both stick levels. They also send a zeroed first stop bit and a low pulse shorter than half a bit. An unread back-to-back pair must report an overrun, and a line held low for two frames must report a break.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    // Field positions inside the framing word
    localparam int CFG_LEN_LO = 0;
    localparam int CFG_TWO_STOP = 2;
    localparam int CFG_PAR_EN = 3;
    localparam int CFG_PAR_EVEN = 4;
    localparam int CFG_PAR_STICK = 5;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
        logic       two_stop;
    } frame_fmt_t;

endpackage

// File: rtl/uart_rx_fmt.sv
module uart_rx_fmt
    import uart_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int BRK_W = 8
) (
    input  logic [5:0]       cfg,
    output frame_fmt_t       fmt,
    output logic [BRK_W-1:0] frame_ticks
);

    logic [3:0] bits_total;

    always_comb begin
        fmt.nbits     = 4'd5 + {2'b00, cfg[CFG_LEN_LO+1:CFG_LEN_LO]};
        fmt.par_en    = cfg[CFG_PAR_EN];
        fmt.par_even  = cfg[CFG_PAR_EVEN];
        fmt.par_stick = cfg[CFG_PAR_STICK];
        fmt.two_stop  = cfg[CFG_TWO_STOP];
        bits_total    = 4'd2 + fmt.nbits + {3'b000, fmt.par_en} + {3'b000, fmt.two_stop};
        frame_ticks   = BRK_W'(bits_total) * BRK_W'(OSR);
    end

endmodule

// File: rtl/uart_rx_deframe.sv
module uart_rx_deframe
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    input  frame_fmt_t    fmt,
    output logic          done,
    output logic [DW-1:0] char_out,
    output logic          par_bad,
    output logic          stop_bad
);

    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DW);
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    sh;
        logic             acc;
        logic             pbad;
        logic             fbad;
        logic             done;
    } df_t;

    df_t s_d, s_q;
    logic exp_par;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        exp_par  = fmt.par_stick ? ~fmt.par_even : (fmt.par_even ? s_q.acc : ~s_q.acc);
        if (tick) begin
            case (s_q.st)
                RX_IDLE: begin
                    if (!rx) begin
                        s_d.st  = RX_START;
                        s_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (s_q.cnt == HALF_M1) begin
                        s_d.cnt  = '0;
                        s_d.idx  = '0;
                        s_d.sh   = '0;
                        s_d.acc  = 1'b0;
                        s_d.pbad = 1'b0;
                        s_d.st   = rx ? RX_IDLE : RX_DATA;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (s_q.cnt == FULL_M1) begin
                        s_d.cnt        = '0;
                        s_d.sh[s_q.idx] = rx;
                        s_d.acc        = s_q.acc ^ rx;
                        if ({1'b0, s_q.idx} == fmt.nbits - 4'd1) begin
                            s_d.st = fmt.par_en ? RX_PAR : RX_STOP;
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (s_q.cnt == FULL_M1) begin
                        s_d.cnt  = '0;
                        s_d.pbad = (rx != exp_par);
                        s_d.st   = RX_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (s_q.cnt == FULL_M1) begin
                        s_d.cnt  = '0;
                        s_d.fbad = !rx;
                        s_d.done = 1'b1;
                        s_d.st   = RX_IDLE;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: s_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: RX_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done     = s_q.done;
    assign char_out = s_q.sh;
    assign par_bad  = s_q.pbad;
    assign stop_bad = s_q.fbad;

    AST_IDX_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == RX_DATA) |-> ({1'b0, s_q.idx} < fmt.nbits)); // R2
    AST_START_CONFIRMED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == RX_DATA && $past(s_q.st) == RX_START) |-> $past(!rx)); // R9
    AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(s_q.st) == RX_STOP && s_q.st == RX_IDLE)); // R5

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
    parameter int DW    = 8,
    parameter int BRK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx,
    input  logic             done,
    input  logic [DW-1:0]    char_in,
    input  logic             par_bad,
    input  logic             stop_bad,
    input  logic [BRK_W-1:0] frame_ticks,
    input  logic             rd_data,
    input  logic             rd_status,
    output logic [DW-1:0]    rbr,
    output logic             dr,
    output logic             oe,
    output logic             pe,
    output logic             fe,
    output logic             bi
);

    typedef struct packed {
        logic [DW-1:0]    rbr;
        logic             dr;
        logic             oe;
        logic             pe;
        logic             fe;
        logic             bi;
        logic [BRK_W-1:0] low;
    } st_t;

    st_t s_d, s_q;
    logic brk_hit;

    always_comb begin
        s_d     = s_q;
        brk_hit = 1'b0;
        if (tick) begin
            if (rx) begin
                s_d.low = '0;
            end else if (s_q.low <= frame_ticks) begin
                s_d.low = s_q.low + 1'b1;
                brk_hit = (s_q.low == frame_ticks);
            end
        end
        s_d.dr = done | (s_q.dr & ~rd_data);
        s_d.oe = (done & s_q.dr & ~rd_data) | (s_q.oe & ~rd_status);
        s_d.pe = (done & par_bad) | (s_q.pe & ~rd_status);
        s_d.fe = (done & stop_bad) | (s_q.fe & ~rd_status);
        s_d.bi = brk_hit | (s_q.bi & ~rd_status);
        if (done) begin
            s_d.rbr = char_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rbr = s_q.rbr;
    assign dr  = s_q.dr;
    assign oe  = s_q.oe;
    assign pe  = s_q.pe;
    assign fe  = s_q.fe;
    assign bi  = s_q.bi;

    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> dr); // R7
    AST_OVERRUN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(dr)); // R8
    AST_BREAK_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bi) |-> $past(!rx)); // R6
    AST_READ_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !done) |=> !dr); // R10

endmodule

// File: rtl/uart_rx_line.sv
module uart_rx_line
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx_in,
    input  logic [5:0] frame_cfg,
    input  logic       rd_data,
    input  logic       rd_status,
    output logic [7:0] rx_char,
    output logic       data_ready,
    output logic       overrun,
    output logic       parity_err,
    output logic       framing_err,
    output logic       break_det
);

    localparam int DW    = 8;
    localparam int BRK_W = $clog2((DW + 4) * OSR + 2);

    frame_fmt_t       fmt;
    logic [BRK_W-1:0] frame_ticks;
    logic             done;
    logic [DW-1:0]    char_w;
    logic             par_bad;
    logic             stop_bad;

    uart_rx_fmt #(.OSR(OSR), .BRK_W(BRK_W)) u_fmt (
        .cfg         (frame_cfg),
        .fmt         (fmt),
        .frame_ticks (frame_ticks)
    );

    uart_rx_deframe #(.OSR(OSR), .DW(DW)) u_deframe (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .rx       (rx_in),
        .fmt      (fmt),
        .done     (done),
        .char_out (char_w),
        .par_bad  (par_bad),
        .stop_bad (stop_bad)
    );

    uart_rx_status #(.DW(DW), .BRK_W(BRK_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .rx          (rx_in),
        .done        (done),
        .char_in     (char_w),
        .par_bad     (par_bad),
        .stop_bad    (stop_bad),
        .frame_ticks (frame_ticks),
        .rd_data     (rd_data),
        .rd_status   (rd_status),
        .rbr         (rx_char),
        .dr          (data_ready),
        .oe          (overrun),
        .pe          (parity_err),
        .fe          (framing_err),
        .bi          (break_det)
    );

endmodule

// File: tb/uart_rx_line_test.sv
module uart_rx_line_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_in = 1'b1;
    logic [5:0] frame_cfg = 6'b000011;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] rx_char;
    logic       data_ready, overrun, parity_err, framing_err, break_det;

    int checks = 0;
    int errors = 0;

    uart_rx_line uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
        .frame_cfg(frame_cfg), .rd_data(rd_data), .rd_status(rd_status),
        .rx_char(rx_char), .data_ready(data_ready), .overrun(overrun),
        .parity_err(parity_err), .framing_err(framing_err), .break_det(break_det)
    );

    always #5 clk = ~clk;
    always @(negedge clk) tick16 <= ~tick16;  // tick every other cycle: 32 clocks per bit

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx_in = b;
        repeat (32) @(negedge clk);
    endtask

    // pm: 0 none, 1 odd, 2 even, 3 stick with even=0, 4 stick with even=1
    function automatic logic [5:0] mk_cfg(input int wl, input int pm, input bit s2);
        logic [5:0] c;
        c[1:0] = wl[1:0];
        c[2]   = s2;
        c[3]   = (pm != 0);
        c[4]   = (pm == 2 || pm == 4);
        c[5]   = (pm >= 3);
        return c;
    endfunction

    task automatic send_frame(input int wl, input int pm, input bit s2, input logic [7:0] d,
                              input bit bad_par, input bit bad_stop);
        int  nb = 5 + wl;
        logic p = 1'b0;
        frame_cfg = mk_cfg(wl, pm, s2);
        for (int i = 0; i < nb; i++) p ^= d[i];
        case (pm)
            1: p = ~p;
            3: p = 1'b1;
            4: p = 1'b0;
            default: ;
        endcase
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(d[i]);
        if (pm != 0) send_bit(p ^ bad_par);
        send_bit(!bad_stop);
        if (s2) send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic read_all();
        rd_data = 1'b1; rd_status = 1'b1;
        @(negedge clk);
        rd_data = 1'b0; rd_status = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_all();
        logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(data_ready == 0 && overrun == 0 && parity_err == 0 && framing_err == 0 && break_det == 0,
            "R11 flags", {data_ready, overrun, parity_err, framing_err, break_det}, 0);
        chk(rx_char == 0, "R11 char", rx_char, 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);

        // Clean-frame sweep
        for (int wl = 0; wl < 4; wl++)
            for (int pm = 0; pm < 5; pm++)
                for (int s2 = 0; s2 < 2; s2++)
                    for (int k = 0; k < 4; k++) begin
                        logic [7:0] e = pats[k] & 8'((1 << (5 + wl)) - 1);
                        send_frame(wl, pm, s2[0], pats[k], 1'b0, 1'b0);
                        chk(rx_char == e, "R1 R2 char", rx_char, e);
                        chk(data_ready == 1, "R7 ready", data_ready, 1);
                        chk(parity_err == 0, (pm >= 3) ? "R4 no perr" : "R3 no perr", parity_err, 0);
                        chk(framing_err == 0, "R5 no ferr", framing_err, 0);
                        chk(break_det == 0, "R6 no break", break_det, 0);
                        chk(overrun == 0, "R8 no overrun", overrun, 0);
                        read_all();
                        chk(data_ready == 0, "R10 ready clear", data_ready, 0);
                    end

        // Bad parity in every parity mode
        for (int pm = 1; pm < 5; pm++) begin
            send_frame(3, pm, 1'b0, 8'h6C, 1'b1, 1'b0);
            chk(parity_err == 1, (pm >= 3) ? "R4 stick perr" : "R3 perr", parity_err, 1);
            chk(rx_char == 8'h6C, "R7 char with perr", rx_char, 8'h6C);
            read_all();
            chk(parity_err == 0, "R10 perr clear", parity_err, 0);
        end

        // Zero first stop bit, two-stop format
        send_frame(3, 0, 1'b1, 8'h01, 1'b0, 1'b1);
        chk(framing_err == 1, "R5 ferr", framing_err, 1);
        chk(break_det == 0, "R6 short low", break_det, 0);
        chk(data_ready == 1, "R9 one char only", data_ready, 1);
        read_all();
        chk(framing_err == 0, "R10 ferr clear", framing_err, 0);

        // Overrun
        send_frame(3, 0, 1'b0, 8'h11, 1'b0, 1'b0);
        send_frame(3, 0, 1'b0, 8'h22, 1'b0, 1'b0);
        chk(overrun == 1, "R8 overrun", overrun, 1);
        chk(rx_char == 8'h22, "R8 newer kept", rx_char, 8'h22);
        rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
        chk(overrun == 1, "R10 data read keeps overrun", overrun, 1);
        read_all();
        chk(overrun == 0, "R10 overrun clear", overrun, 0);

        // False start: low for 4 ticks only
        frame_cfg = mk_cfg(3, 0, 1'b0);
        rx_in = 1'b0; repeat (8) @(negedge clk);
        rx_in = 1'b1; repeat (400) @(negedge clk);
        chk(data_ready == 0, "R9 false start", data_ready, 0);
        send_frame(1, 2, 1'b0, 8'h2B, 1'b0, 1'b0);
        chk(rx_char == 8'h2B && data_ready == 1, "R9 recover", rx_char, 8'h2B);
        read_all();

        // Break: low for two full frames
        frame_cfg = mk_cfg(3, 0, 1'b0);
        rx_in = 1'b0; repeat (20 * 32) @(negedge clk);
        chk(break_det == 1, "R6 break", break_det, 1);
        rx_in = 1'b1; repeat (14 * 32) @(negedge clk);
        chk(framing_err == 1, "R5 ferr in break", framing_err, 1);
        chk(break_det == 1, "R6 break held", break_det, 1);
        read_all();
        chk(break_det == 0, "R10 break clear", break_det, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule